// File: doc/BRIEF.md
# Programmable-Trigger Interrupt Controller

This block collects eight raw condition signals and turns them into one interrupt line. Each source has its own trigger setting: it can fire when its condition starts, fire when its condition ends, or follow the condition for as long as it lasts. A per-source enable bit decides whether the source can record a status bit and whether it can assert the line. The line's active sense is chosen on its own, separate from any trigger setting.

Software uses a small register port to set things up and to service interrupts. The trigger code for each source is split across two byte registers: one holds the upper bit of every source's code and the other holds the lower bit, at the same bit position. Edge-triggered status bits stay set until software reads the status register; reading clears them. Level-triggered status bits track the condition and do not need to be cleared.

Every condition input passes through a two-stage synchronizer. Edges are found by comparing the synchronized value with a registered copy of its previous value.

Top module: `irq_mode_ctrl`

## Requirements
- R1: After reset, the enable, mode-high, mode-low and control registers and the status register all read 0x00, and `irq_o` is low.
- R2: The trigger code of source i is {mode-high[i], mode-low[i]}: 00 start of condition, 01 end of condition, 10 level, 11 disabled.
- R3: With code 00, a rising condition sets status bit i on the third clock edge after the input changes. The bit stays set after the condition falls.
- R4: With code 01, a falling condition sets status bit i, and a rising condition does not.
- R5: With code 10, status bit i equals the synchronized condition (gated by its enable bit) with the same three-edge latency in both directions, and a status read does not clear it.
- R6: With code 11, the source never sets its status bit, whether its condition rises or falls.
- R7: When enable bit i is 0, source i sets no status bit, and a status bit that is already set no longer asserts the pin.
- R8: A read of address 0 returns the status value on `rd_data_o` one cycle later and clears every edge-latched bit. If an edge is detected on the same clock edge as the clear, that bit stays set.
- R9: The pin is driven from the OR of all status bits whose enable bit is set, shaped by control bits [1:0]: 00 gives active-high, 01 gives active-low, and 10 or 11 hold the pin low.
- R10: The register map is address 1 enable, 2 mode-high, 3 mode-low, 4 control (bits [1:0] only, upper bits read 0). Writes read back one cycle after the read. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data, valid the cycle after the strobe and held until the next read |
| cond_i | input | 8 | Raw condition inputs, one per source |
| irq_o | output | 1 | Interrupt line |

## Verification
A change on a condition input reaches the status register and the pin on the third rising edge after the change: two edges go through the synchronizer and one into the status flop. Register reads appear one edge after the strobe, and a status clear takes effect on that same edge. The bench drives inputs at falling edges and samples at the following falling edges, counting edges exactly. It checks the pin after edge two (still idle) and after edge three (changed), and it places a read on the very edge where an edge-triggered bit is set. During the random phase, a cycle-by-cycle bench model predicts the pin and the read data, and both are compared at every falling edge.

// File: rtl/irq_mode_pkg.sv
`timescale 1ns/1ps
package irq_mode_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    // Register addresses seen by the read/write port
    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS  = 3'd0,
        REG_ENABLE  = 3'd1,
        REG_MODE_HI = 3'd2,
        REG_MODE_LO = 3'd3,
        REG_CTRL    = 3'd4
    } reg_addr_e;

    // Per-source trigger code, {high bit, low bit}
    typedef enum logic [1:0] {
        TRIG_RISE  = 2'b00,
        TRIG_FALL  = 2'b01,
        TRIG_LEVEL = 2'b10,
        TRIG_OFF   = 2'b11
    } trig_e;

    // Pin shaping selected by the control register
    typedef enum logic [1:0] {
        POL_HIGH   = 2'b00,
        POL_LOW    = 2'b01,
        POL_QUIET0 = 2'b10,
        POL_QUIET1 = 2'b11
    } pol_e;

    // Edge events derived for one source
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_s;

    function automatic trig_e trig_of(input logic hi, input logic lo);
        return trig_e'({hi, lo});
    endfunction

    function automatic edge_s edges_of(input logic cur, input logic prev);
        edge_s e;
        e.rise = cur & ~prev;
        e.fall = ~cur & prev;
        return e;
    endfunction

    function automatic logic pin_drive(input pol_e p, input logic any);
        logic r;
        case (p)
            POL_HIGH: r = any;
            POL_LOW:  r = ~any;
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irq_mode_sync.sv
`timescale 1ns/1ps
module irq_mode_sync #(
    parameter int NSRC   = 8,
    parameter int STAGES = 2
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [NSRC-1:0] raw_i,
    output logic [NSRC-1:0] cur_o,
    output logic [NSRC-1:0] prev_o
);

    localparam int LAST = STAGES - 1;

    logic [NSRC-1:0] stage_q [STAGES];
    logic [NSRC-1:0] prev_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk_i) begin
                if (rst_i) stage_q[g] <= '0;
                else       stage_q[g] <= raw_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i) begin
                if (rst_i) stage_q[g] <= '0;
                else       stage_q[g] <= stage_q[g-1];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= '0;
        else       prev_q <= stage_q[LAST];
    end

    assign cur_o  = stage_q[LAST];
    assign prev_o = prev_q;

endmodule

// File: rtl/irq_mode_regs.sv
`timescale 1ns/1ps
module irq_mode_regs
    import irq_mode_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [NSRC-1:0]   status_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [NSRC-1:0]   enable_o,
    output logic [NSRC-1:0]   mode_hi_o,
    output logic [NSRC-1:0]   mode_lo_o,
    output pol_e              pol_o,
    output logic              status_clr_o
);

    logic [NSRC-1:0]   enable_q;
    logic [NSRC-1:0]   mode_hi_q;
    logic [NSRC-1:0]   mode_lo_q;
    logic [1:0]        ctrl_q;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            enable_q  <= '0;
            mode_hi_q <= '0;
            mode_lo_q <= '0;
            ctrl_q    <= '0;
        end else if (wr_en_i) begin
            case (wr_addr_i)
                REG_ENABLE:  enable_q  <= wr_data_i[NSRC-1:0];
                REG_MODE_HI: mode_hi_q <= wr_data_i[NSRC-1:0];
                REG_MODE_LO: mode_lo_q <= wr_data_i[NSRC-1:0];
                REG_CTRL:    ctrl_q    <= wr_data_i[1:0];
                default:     ;
            endcase
        end
    end

    always_comb begin
        rd_mux = '0;
        case (rd_addr_i)
            REG_STATUS:  rd_mux = DATA_W'(status_i);
            REG_ENABLE:  rd_mux = DATA_W'(enable_q);
            REG_MODE_HI: rd_mux = DATA_W'(mode_hi_q);
            REG_MODE_LO: rd_mux = DATA_W'(mode_lo_q);
            REG_CTRL:    rd_mux = DATA_W'(ctrl_q);
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)        rd_q <= '0;
        else if (rd_en_i) rd_q <= rd_mux;
    end

    assign rd_data_o    = rd_q;
    assign enable_o     = enable_q;
    assign mode_hi_o    = mode_hi_q;
    assign mode_lo_o    = mode_lo_q;
    assign pol_o        = pol_e'(ctrl_q);
    assign status_clr_o = rd_en_i && (rd_addr_i == REG_STATUS);

endmodule

// File: rtl/irq_mode_detect.sv
`timescale 1ns/1ps
module irq_mode_detect
    import irq_mode_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [NSRC-1:0] cur_i,
    input  logic [NSRC-1:0] prev_i,
    input  logic [NSRC-1:0] enable_i,
    input  logic [NSRC-1:0] mode_hi_i,
    input  logic [NSRC-1:0] mode_lo_i,
    input  logic            clr_i,
    output logic [NSRC-1:0] status_o
);

    logic [NSRC-1:0] status_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        trig_e trig;
        edge_s ev;
        logic  hit;

        always_comb begin
            trig = trig_of(mode_hi_i[i], mode_lo_i[i]);
            ev   = edges_of(cur_i[i], prev_i[i]);
            case (trig)
                TRIG_RISE: hit = ev.rise;
                TRIG_FALL: hit = ev.fall;
                default:   hit = 1'b0;
            endcase
        end

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                status_q[i] <= 1'b0;
            end else if (trig == TRIG_LEVEL) begin
                status_q[i] <= cur_i[i] & enable_i[i];
            end else begin
                // a fresh edge outranks a clear on the same edge
                status_q[i] <= (hit & enable_i[i]) | (status_q[i] & ~clr_i);
            end
        end
    end

    assign status_o = status_q;

endmodule

// File: rtl/irq_mode_ctrl.sv
`timescale 1ns/1ps
module irq_mode_ctrl
    import irq_mode_pkg::*;
#(
    parameter int NSRC       = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic [NSRC-1:0]   cond_i,
    output logic              irq_o
);

    logic [NSRC-1:0] cur_s;
    logic [NSRC-1:0] prev_s;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] mode_hi_q;
    logic [NSRC-1:0] mode_lo_q;
    logic [NSRC-1:0] status_q;
    pol_e            pol_q;
    logic            clr_s;

    irq_mode_sync #(.NSRC(NSRC), .STAGES(SYNC_DEPTH)) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .raw_i  (cond_i),
        .cur_o  (cur_s),
        .prev_o (prev_s)
    );

    irq_mode_regs #(.NSRC(NSRC)) u_regs (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .rd_en_i      (rd_en_i),
        .rd_addr_i    (rd_addr_i),
        .status_i     (status_q),
        .rd_data_o    (rd_data_o),
        .enable_o     (mask_q),
        .mode_hi_o    (mode_hi_q),
        .mode_lo_o    (mode_lo_q),
        .pol_o        (pol_q),
        .status_clr_o (clr_s)
    );

    irq_mode_detect #(.NSRC(NSRC)) u_detect (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .cur_i     (cur_s),
        .prev_i    (prev_s),
        .enable_i  (mask_q),
        .mode_hi_i (mode_hi_q),
        .mode_lo_i (mode_lo_q),
        .clr_i     (clr_s),
        .status_o  (status_q)
    );

    assign irq_o = pin_drive(pol_q, |(status_q & mask_q));

endmodule

// File: rtl/irq_mode_chk.sv
`timescale 1ns/1ps
module irq_mode_chk
    import irq_mode_pkg::*;
#(
    parameter int NSRC = 8
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              irq_o,
    input logic [1:0]        pol_q,
    input logic [NSRC-1:0]   mask_q,
    input logic [NSRC-1:0]   mode_hi_q,
    input logic [NSRC-1:0]   mode_lo_q,
    input logic [NSRC-1:0]   cur_s,
    input logic [NSRC-1:0]   status_q
);

    logic [NSRC-1:0]   level_en;
    logic [NSRC-1:0]   off_en;
    logic [DATA_W-1:0] status_ext;

    assign level_en   = mode_hi_q & ~mode_lo_q & mask_q;
    assign off_en     = mode_hi_q & mode_lo_q;
    assign status_ext = DATA_W'(status_q);

    // R5: level sources mirror the synchronized condition one edge later
    p_level_follow_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (((status_q ^ $past(cur_s)) & $past(level_en)) == '0));

    // R6: a disabled code never raises a status bit
    p_off_quiet_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((status_q & ~$past(status_q) & $past(off_en)) == '0));

    // R7: a source without its enable bit never raises a status bit
    p_masked_quiet_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(mask_q)) == '0));

    // R8: a status read returns the value held on the strobe edge
    p_status_read_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_en_i && rd_addr_i == REG_STATUS) |=> (rd_data_o == $past(status_ext)));

    // R9: the quiet settings keep the pin low
    p_quiet_pin_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        pol_q[1] |-> !irq_o);

    // R10: upper control bits always read as zero
    p_ctrl_pad_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_en_i && rd_addr_i == REG_CTRL) |=> (rd_data_o[DATA_W-1:2] == '0));

endmodule

bind irq_mode_ctrl irq_mode_chk #(.NSRC(NSRC)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .irq_o     (irq_o),
    .pol_q     (pol_q),
    .mask_q    (mask_q),
    .mode_hi_q (mode_hi_q),
    .mode_lo_q (mode_lo_q),
    .cur_s     (cur_s),
    .status_q  (status_q)
);

// File: tb/irq_mode_ctrl_tb.sv
`timescale 1ns/1ps
module irq_mode_ctrl_tb;

    localparam int NSRC = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [7:0] cond = '0;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_mode_ctrl #(.NSRC(NSRC)) u_dut (
        .clk_i     (clk),
        .rst_i     (rst),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_en_i   (rd_en),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .cond_i    (cond),
        .irq_o     (irq)
    );

    // ---------------- bench model, built from the requirements ----------------
    logic [7:0] m_s1, m_s2, m_prev, m_stat, m_en, m_hi, m_lo, m_rd;
    logic [1:0] m_ctrl;

    function automatic logic exp_pin(input logic [7:0] st, input logic [7:0] en,
                                     input logic [1:0] ctrl);
        logic any;
        any = |(st & en);
        if (ctrl == 2'b00) return any;
        if (ctrl == 2'b01) return ~any;
        return 1'b0;
    endfunction

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return m_stat;
            3'd1: return m_en;
            3'd2: return m_hi;
            3'd3: return m_lo;
            3'd4: return {6'b0, m_ctrl};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [7:0] nxt;
        logic       clr;
        if (rst) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_stat <= '0;
            m_en <= '0; m_hi <= '0; m_lo <= '0; m_ctrl <= '0; m_rd <= '0;
        end else begin
            clr = rd_en && rd_addr == 3'd0;
            for (int i = 0; i < NSRC; i++) begin
                case ({m_hi[i], m_lo[i]})
                    2'b10:   nxt[i] = m_s2[i] & m_en[i];
                    2'b00:   nxt[i] = (m_s2[i] & ~m_prev[i] & m_en[i]) | (m_stat[i] & ~clr);
                    2'b01:   nxt[i] = (~m_s2[i] & m_prev[i] & m_en[i]) | (m_stat[i] & ~clr);
                    default: nxt[i] = m_stat[i] & ~clr;
                endcase
            end
            if (rd_en) m_rd <= exp_read(rd_addr);
            m_stat <= nxt;
            m_s1 <= cond; m_s2 <= m_s1; m_prev <= m_s2;
            if (wr_en) begin
                case (wr_addr)
                    3'd1: m_en   <= wr_data;
                    3'd2: m_hi   <= wr_data;
                    3'd3: m_lo   <= wr_data;
                    3'd4: m_ctrl <= wr_data[1:0];
                    default: ;
                endcase
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [7:0] d;
        void'($urandom(32'd20240611));
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1: reset state
        rd(3'd1, d); check("R1 enable reset", d, 8'h00);
        rd(3'd2, d); check("R1 mode-high reset", d, 8'h00);
        rd(3'd3, d); check("R1 mode-low reset", d, 8'h00);
        rd(3'd4, d); check("R1 control reset", d, 8'h00);
        rd(3'd0, d); check("R1 status reset", d, 8'h00);
        check("R1 pin reset", irq, 1'b0);

        // R10: register map and readback
        wr(3'd1, 8'hA5); rd(3'd1, d); check("R10 enable readback", d, 8'hA5);
        wr(3'd1, 8'hFF);
        wr(3'd4, 8'hFF); rd(3'd4, d); check("R10 control pad", d, 8'h03);
        wr(3'd4, 8'h00);
        rd(3'd7, d); check("R10 unmapped read", d, 8'h00);

        // R3: rising trigger, source 0
        cond[0] = 1'b1;
        tick(2); check("R3 pin idle after two edges", irq, 1'b0);
        tick(1); check("R3 pin set on third edge", irq, 1'b1);
        cond[0] = 1'b0;
        tick(5); check("R3 bit latched after condition ends", irq, 1'b1);
        rd(3'd0, d); check("R8 status value read", d, 8'h01);
        check("R8 pin cleared by read", irq, 1'b0);
        rd(3'd0, d); check("R8 status empty after clear", d, 8'h00);

        // R4: falling trigger, source 1 (mode-low bit 1)
        wr(3'd3, 8'h02);
        cond[1] = 1'b1; tick(5);
        rd(3'd0, d); check("R4 no fire on rise", d, 8'h00);
        cond[1] = 1'b0; tick(4);
        rd(3'd0, d); check("R4 fire on fall", d, 8'h02);

        // R2/R5: level trigger via mode-high bit 2
        wr(3'd2, 8'h04);
        cond[2] = 1'b1; tick(4);
        check("R5 level pin asserted", irq, 1'b1);
        rd(3'd0, d); check("R2 level code from high bit", d, 8'h04);
        check("R5 level survives read", irq, 1'b1);
        cond[2] = 1'b0;
        tick(2); check("R5 level held two edges", irq, 1'b1);
        tick(1); check("R5 level drops on third edge", irq, 1'b0);

        // R6: code 11 on source 3
        wr(3'd2, 8'h0C); wr(3'd3, 8'h0A);
        cond[3] = 1'b1; tick(5); cond[3] = 1'b0; tick(5);
        rd(3'd0, d); check("R6 disabled code silent", d, 8'h00);
        check("R6 pin silent", irq, 1'b0);

        // R7: masked source 0 cannot set status
        wr(3'd1, 8'hFE);
        cond[0] = 1'b1; tick(4); cond[0] = 1'b0; tick(4);
        check("R7 masked pin", irq, 1'b0);
        wr(3'd1, 8'hFF);
        rd(3'd0, d); check("R7 masked status", d, 8'h00);

        // R7/R9: latched bit on source 4 vs enable and polarity
        cond[4] = 1'b1; tick(4);
        check("R7 source 4 pending", irq, 1'b1);
        wr(3'd1, 8'hEF); check("R7 mask hides pending bit", irq, 1'b0);
        wr(3'd1, 8'hFF); check("R7 unmask shows pending bit", irq, 1'b1);
        wr(3'd4, 8'h01); check("R9 active-low pending", irq, 1'b0);
        wr(3'd4, 8'h02); check("R9 quiet setting with pending", irq, 1'b0);
        wr(3'd4, 8'h01);
        rd(3'd0, d); check("R9 active-low idle after clear", irq, 1'b1);
        wr(3'd4, 8'h03); check("R9 quiet setting idle", irq, 1'b0);
        wr(3'd4, 8'h00);
        cond[4] = 1'b0; tick(4);

        // R8: edge on the same clock edge as the clear wins
        cond[4] = 1'b1;
        tick(2);
        rd_en = 1'b1; rd_addr = 3'd0;
        @(negedge clk);
        rd_en = 1'b0;
        check("R8 read before set", rd_data, 8'h00);
        check("R8 same-edge set kept", irq, 1'b1);
        rd(3'd0, d); check("R8 bit still reported", d, 8'h10);
        cond[4] = 1'b0; tick(4);

        // random phase against the bench model (R2..R10 together)
        for (int cyc = 0; cyc < 3000; cyc++) begin
            check("R9 model pin", irq, exp_pin(m_stat, m_en, m_ctrl));
            check("R8 model read data", rd_data, m_rd);
            wr_en = 1'b0; rd_en = 1'b0;
            if ($urandom_range(0, 3) == 0) cond = cond ^ 8'($urandom());
            if ($urandom_range(0, 19) == 0) begin
                wr_en = 1'b1;
                wr_addr = 3'($urandom_range(1, 5));
                wr_data = 8'($urandom());
            end
            if ($urandom_range(0, 5) == 0) begin
                rd_en = 1'b1;
                rd_addr = ($urandom_range(0, 2) == 0) ? 3'($urandom_range(0, 7)) : 3'd0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0; rd_en = 1'b0;
        tick(1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule